// File: doc/BRIEF.md
# UART Interrupt Source and Line Status Logic

This block produces the interrupt request, the interrupt identification code and the eight-bit line status value for one UART channel that has receive and transmit FIFOs. The FIFOs, the shifters and the baud generator live elsewhere. They report to this block through occupancy counts, a transmitter-busy flag, the error flags of the character at the receive FIFO head, an overrun pulse, and push/pop strobes that say whether a character entering or leaving the receive FIFO carries an error. The register front end passes in strobes for reads of the interrupt identification register, reads of the line status register, and writes to the transmit holding register.

Three interrupt sources are ranked. Line status errors come first, then receive data at the trigger level, then transmit empty. The receive source is level based. It is asserted while the receive FIFO holds at least the selected trigger count, and it deasserts on its own when the count falls below that level. The transmit source is held by a three-state machine. TX_QUIET is the reset state: FIFO empty, nothing pending. TX_LOADED means the FIFO holds data. TX_ALERT means the FIFO has drained and an interrupt is pending. The transitions are:

- any state to TX_LOADED on a holding-register write
- TX_QUIET to TX_LOADED when the count becomes non-zero
- TX_LOADED to TX_ALERT when the count reaches zero
- TX_ALERT to TX_LOADED when the count becomes non-zero
- TX_ALERT to TX_QUIET when the identification register is read while it reports transmit empty

With all interrupt enables clear, the block runs in polled mode. No interrupt is raised, and the line status value keeps tracking the channel.

Top module: `uart_isr_core`

## Requirements
- R1: After reset, with all inputs low, `irq` is 0, `iid` is 3'b000 and `lsr` is 8'h60.
- R2: The receive source is active when `int_en[0]` is set and `rx_count` is at or above the trigger level. With `fifo_en`=1, `trig_sel` values 0, 1, 2 and 3 give levels 1, DEPTH/4, DEPTH/2 and DEPTH-2. With `fifo_en`=0 the level is 1. The source drops as soon as the count falls below the level.
- R3: The transmit source becomes pending one clock after the state machine, in TX_LOADED, sees `tx_count`=0. It is reported only while `int_en[1]` is set. It is never pending after reset, and it is not re-armed while the FIFO stays empty.
- R4: A pending transmit source is cleared by an `isr_rd` pulse in a cycle where `iid` is 3'b001, or by a `thr_wr` pulse. An `isr_rd` while a higher source is reported leaves it pending.
- R5: `iid` reports the highest active source: 3'b011 line status, 3'b010 receive data, 3'b001 transmit empty, 3'b000 none. `irq` is 1 exactly when `iid` is non-zero.
- R6: With `int_en`=0, `irq` stays 0 and `iid` stays 3'b000, while every `lsr` bit continues to update.
- R7: `lsr[0]` is 1 when `rx_count`≠0. `lsr[5]` is 1 when `tx_count`=0. `lsr[6]` is 1 when `tx_count`=0 and `tsr_busy`=0.
- R8: `lsr[2]`, `lsr[3]` and `lsr[4]` show `head_par`, `head_frm` and `head_brk` while `rx_count`≠0, and are 0 when the receive FIFO is empty.
- R9: `lsr[1]` is set one clock after an `ovr_evt` pulse. It holds until an `lsr_rd` pulse in a cycle without `ovr_evt`. A coincident `ovr_evt` wins.
- R10: `lsr[7]` is 1 while `fifo_en`=1 and at least one character marked as erroneous (pushed with `rx_wr` and `rx_wr_err`) has not yet been popped with `rx_rd` and `rx_rd_err`. It updates one clock after the strobe.
- R11: The line status source is active when `int_en[2]` is set and any of `lsr[4:1]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFO mode enable |
| int_en | input | 3 | Enables: [0] receive data, [1] transmit empty, [2] line status |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CW | Receive FIFO occupancy |
| tx_count | input | CW | Transmit FIFO occupancy |
| tsr_busy | input | 1 | Transmit shift register holds a character |
| head_par | input | 1 | Parity error on receive head character |
| head_frm | input | 1 | Framing error on receive head character |
| head_brk | input | 1 | Break on receive head character |
| ovr_evt | input | 1 | Overrun pulse |
| rx_wr | input | 1 | Character pushed into receive FIFO |
| rx_wr_err | input | 1 | Pushed character carries an error |
| rx_rd | input | 1 | Character popped from receive FIFO |
| rx_rd_err | input | 1 | Popped character carried an error |
| isr_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| irq | output | 1 | Interrupt request |
| iid | output | 3 | Interrupt identification code |
| lsr | output | 8 | Line status value |

## Verification
The hardest situation to reach from the ports is an acknowledge that must be ignored. The transmit source has to be pending underneath a receive interrupt of higher rank when the identification read arrives. The stimulus first drains a loaded transmit FIFO so that TX_ALERT is entered. It then raises the receive count to the trigger level and pulses `isr_rd`. After that it drops the receive count and expects code 3'b001 to surface. A second hard spot is the erroneous-character tally behind `lsr[7]`. The bench runs a mixed push and pop sequence and tracks its own model of the FIFO, so that the bit must stay set until the last marked character leaves.

// File: rtl/uart_isr_pkg.sv
package uart_isr_pkg;

    typedef enum logic [1:0] {
        TX_QUIET  = 2'd0,
        TX_LOADED = 2'd1,
        TX_ALERT  = 2'd2
    } tx_state_t;

    typedef enum logic [2:0] {
        IID_NONE = 3'b000,
        IID_TXE  = 3'b001,
        IID_RXD  = 3'b010,
        IID_LINE = 3'b011
    } iid_t;

endpackage

// File: rtl/uart_isr_rx_level.sv
module uart_isr_rx_level #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          fifo_en,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] rx_count,
    output logic          rx_hit
);
    localparam logic [CW-1:0] LVL_Q = CW'(DEPTH / 4);
    localparam logic [CW-1:0] LVL_H = CW'(DEPTH / 2);
    localparam logic [CW-1:0] LVL_F = CW'(DEPTH - 2);

    logic [CW-1:0] level;

    always_comb begin
        unique case (trig_sel)
            2'd0: level = CW'(1);
            2'd1: level = LVL_Q;
            2'd2: level = LVL_H;
            2'd3: level = LVL_F;
            default: level = CW'(1);
        endcase
        if (!fifo_en) level = CW'(1);
    end

    assign rx_hit = (rx_count >= level);
endmodule

// File: rtl/uart_isr_lsr.sv
module uart_isr_lsr #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          tsr_busy,
    input  logic          head_par,
    input  logic          head_frm,
    input  logic          head_brk,
    input  logic          ovr_evt,
    input  logic          lsr_rd,
    input  logic          rx_wr,
    input  logic          rx_wr_err,
    input  logic          rx_rd,
    input  logic          rx_rd_err,
    output logic [7:0]    lsr,
    output logic          line_err
);
    logic          ovr_q;
    logic [CW-1:0] err_cnt;
    logic          inc, dec, have_rx;

    assign inc     = rx_wr & rx_wr_err;
    assign dec     = rx_rd & rx_rd_err;
    assign have_rx = (rx_count != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q   <= 1'b0;
            err_cnt <= '0;
        end else begin
            if (ovr_evt)     ovr_q <= 1'b1;
            else if (lsr_rd) ovr_q <= 1'b0;
            unique case ({inc, dec})
                2'b10:   err_cnt <= err_cnt + 1'b1;
                2'b01:   err_cnt <= err_cnt - 1'b1;
                default: err_cnt <= err_cnt;
            endcase
        end
    end

    always_comb begin
        lsr[0] = have_rx;
        lsr[1] = ovr_q;
        lsr[2] = have_rx & head_par;
        lsr[3] = have_rx & head_frm;
        lsr[4] = have_rx & head_brk;
        lsr[5] = (tx_count == '0);
        lsr[6] = (tx_count == '0) & ~tsr_busy;
        lsr[7] = fifo_en & (err_cnt != '0);
    end

    assign line_err = |lsr[4:1];

    AST_ERR_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |-> (err_cnt != '0)); // R10
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> lsr[1]); // R9
    AST_TEMT_IMPLIES_THRE: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6] |-> lsr[5]); // R7
endmodule

// File: rtl/uart_isr_tx_fsm.sv
module uart_isr_tx_fsm
    import uart_isr_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tx_count,
    input  logic          thr_wr,
    input  logic          isr_rd,
    input  logic          tx_selected,
    output logic          tx_flag
);
    tx_state_t state, state_nx;
    logic      empty;

    assign empty = (tx_count == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (thr_wr) begin
            state_nx = TX_LOADED;
        end else begin
            unique case (state)
                TX_QUIET:  if (!empty) state_nx = TX_LOADED;
                TX_LOADED: if (empty)  state_nx = TX_ALERT;
                TX_ALERT: begin
                    if (!empty)                     state_nx = TX_LOADED;
                    else if (isr_rd && tx_selected) state_nx = TX_QUIET;
                end
                default: state_nx = TX_QUIET;
            endcase
        end
    end

    assign tx_flag = (state == TX_ALERT);

    AST_TX_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_ALERT && $past(state) != TX_ALERT) |-> $past(tx_count) == '0); // R3
    AST_TX_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (state != TX_ALERT)); // R4
endmodule

// File: rtl/uart_isr_prio.sv
module uart_isr_prio
    import uart_isr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] int_en,
    input  logic       line_err,
    input  logic       rx_hit,
    input  logic       tx_flag,
    output logic [2:0] iid,
    output logic       irq
);
    logic line_pend, rx_pend, tx_pend;

    assign line_pend = int_en[2] & line_err;
    assign rx_pend   = int_en[0] & rx_hit;
    assign tx_pend   = int_en[1] & tx_flag;

    always_comb begin
        if (line_pend)    iid = IID_LINE;
        else if (rx_pend) iid = IID_RXD;
        else if (tx_pend) iid = IID_TXE;
        else              iid = IID_NONE;
    end

    assign irq = (iid != IID_NONE);

    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en[2] && line_err) |-> (iid == IID_LINE)); // R5
endmodule

// File: rtl/uart_isr_core.sv
module uart_isr_core
    import uart_isr_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [2:0]    int_en,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          tsr_busy,
    input  logic          head_par,
    input  logic          head_frm,
    input  logic          head_brk,
    input  logic          ovr_evt,
    input  logic          rx_wr,
    input  logic          rx_wr_err,
    input  logic          rx_rd,
    input  logic          rx_rd_err,
    input  logic          isr_rd,
    input  logic          lsr_rd,
    input  logic          thr_wr,
    output logic          irq,
    output logic [2:0]    iid,
    output logic [7:0]    lsr
);
    logic rx_hit, line_err, tx_flag, tx_selected;

    assign tx_selected = (iid == IID_TXE);

    uart_isr_rx_level #(.DEPTH(DEPTH)) u_rx (
        .fifo_en(fifo_en), .trig_sel(trig_sel), .rx_count(rx_count), .rx_hit(rx_hit)
    );

    uart_isr_lsr #(.DEPTH(DEPTH)) u_lsr (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_count(rx_count),
        .tx_count(tx_count), .tsr_busy(tsr_busy), .head_par(head_par),
        .head_frm(head_frm), .head_brk(head_brk), .ovr_evt(ovr_evt),
        .lsr_rd(lsr_rd), .rx_wr(rx_wr), .rx_wr_err(rx_wr_err), .rx_rd(rx_rd),
        .rx_rd_err(rx_rd_err), .lsr(lsr), .line_err(line_err)
    );

    uart_isr_tx_fsm #(.DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .thr_wr(thr_wr),
        .isr_rd(isr_rd), .tx_selected(tx_selected), .tx_flag(tx_flag)
    );

    uart_isr_prio u_prio (
        .clk(clk), .rst_n(rst_n), .int_en(int_en), .line_err(line_err),
        .rx_hit(rx_hit), .tx_flag(tx_flag), .iid(iid), .irq(irq)
    );

    AST_POLLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == 3'b000) |-> !irq); // R6
endmodule

// File: tb/tb_uart_isr_core.sv
`timescale 1ns/1ps
module tb_uart_isr_core;
    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n;
    logic fifo_en, tsr_busy, head_par, head_frm, head_brk, ovr_evt;
    logic rx_wr, rx_wr_err, rx_rd, rx_rd_err, isr_rd, lsr_rd, thr_wr;
    logic [2:0] int_en;
    logic [1:0] trig_sel;
    logic [CW-1:0] rx_count, tx_count;
    logic irq;
    logic [2:0] iid;
    logic [7:0] lsr;
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    uart_isr_core #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .int_en(int_en),
        .trig_sel(trig_sel), .rx_count(rx_count), .tx_count(tx_count),
        .tsr_busy(tsr_busy), .head_par(head_par), .head_frm(head_frm),
        .head_brk(head_brk), .ovr_evt(ovr_evt), .rx_wr(rx_wr),
        .rx_wr_err(rx_wr_err), .rx_rd(rx_rd), .rx_rd_err(rx_rd_err),
        .isr_rd(isr_rd), .lsr_rd(lsr_rd), .thr_wr(thr_wr),
        .irq(irq), .iid(iid), .lsr(lsr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fifo_en = 1'b0; int_en = '0; trig_sel = '0;
        rx_count = '0; tx_count = '0; tsr_busy = 1'b0;
        head_par = 1'b0; head_frm = 1'b0; head_brk = 1'b0; ovr_evt = 1'b0;
        rx_wr = 1'b0; rx_wr_err = 1'b0; rx_rd = 1'b0; rx_rd_err = 1'b0;
        isr_rd = 1'b0; lsr_rd = 1'b0; thr_wr = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    function automatic int level_of(input logic fe, input logic [1:0] sel);
        if (!fe) return 1;
        case (sel)
            2'd0: return 1;
            2'd1: return DEPTH / 4;
            2'd2: return DEPTH / 2;
            default: return DEPTH - 2;
        endcase
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        #1;
        chk("R1 irq", irq, 0);
        chk("R1 iid", iid, 3'b000);
        chk("R1 lsr", lsr, 8'h60);

        // R2 sweep of trigger levels, mode and counts
        int_en = 3'b001;
        for (int fe = 0; fe < 2; fe++) begin
            for (int sel = 0; sel < 4; sel++) begin
                for (int c = 0; c <= DEPTH; c++) begin
                    @(negedge clk);
                    fifo_en = fe[0]; trig_sel = sel[1:0]; rx_count = CW'(c);
                    #1;
                    chk("R2 rx iid", iid, (c >= level_of(fe[0], sel[1:0])) ? 3'b010 : 3'b000);
                    chk("R7 lsr0", lsr[0], (c != 0));
                end
            end
        end

        // R7 transmit status sweep
        do_reset();
        for (int t = 0; t < 3; t++) begin
            for (int b = 0; b < 2; b++) begin
                @(negedge clk);
                tx_count = CW'(t); tsr_busy = b[0];
                #1;
                chk("R7 lsr5", lsr[5], (t == 0));
                chk("R7 lsr6", lsr[6], (t == 0) && (b == 0));
            end
        end

        // R3 / R4 transmit interrupt
        do_reset();
        fifo_en = 1'b1; int_en = 3'b010;
        step(); step();
        chk("R3 no tx after reset", irq, 0);
        tx_count = CW'(3); step();
        chk("R3 loaded no irq", irq, 0);
        tx_count = '0; step();
        chk("R3 drain raises", iid, 3'b001);
        chk("R5 irq with tx", irq, 1);
        isr_rd = 1'b1; step(); isr_rd = 1'b0;
        chk("R4 isr_rd clears", irq, 0);
        step(); step(); step();
        chk("R3 no rearm while empty", irq, 0);
        thr_wr = 1'b1; tx_count = CW'(1); step(); thr_wr = 1'b0;
        tx_count = '0; step();
        chk("R3 rearm on drain", iid, 3'b001);
        thr_wr = 1'b1; step(); thr_wr = 1'b0;
        #1;
        chk("R4 thr_wr clears", irq, 0);
        tx_count = CW'(1); step(); tx_count = '0; step();
        chk("R3 pending again", iid, 3'b001);
        int_en = 3'b011; trig_sel = 2'd1; rx_count = CW'(DEPTH / 4);
        #1;
        chk("R5 rx over tx", iid, 3'b010);
        isr_rd = 1'b1; step(); isr_rd = 1'b0;
        rx_count = CW'(DEPTH / 4 - 1);
        #1;
        chk("R4 masked read keeps tx", iid, 3'b001);

        // R8 / R11 / R5 head errors and line status source
        do_reset();
        fifo_en = 1'b1; int_en = 3'b101; head_frm = 1'b1;
        #1;
        chk("R8 empty hides errors", lsr[4:2], 3'b000);
        chk("R11 no line irq when empty", iid, 3'b000);
        rx_count = CW'(1);
        #1;
        chk("R8 framing bit", lsr[4:2], 3'b010);
        chk("R5 line over rx", iid, 3'b011);
        head_frm = 1'b0; head_par = 1'b1; head_brk = 1'b1;
        #1;
        chk("R8 parity and break", lsr[4:2], 3'b101);
        head_par = 1'b0; head_brk = 1'b0;
        #1;
        chk("R2 rx after errors clear", iid, 3'b010);

        // R9 overrun
        do_reset();
        int_en = 3'b100;
        ovr_evt = 1'b1; step(); ovr_evt = 1'b0;
        chk("R9 overrun set", lsr[1], 1);
        chk("R11 line irq on overrun", iid, 3'b011);
        step(); step();
        chk("R9 overrun sticky", lsr[1], 1);
        ovr_evt = 1'b1; lsr_rd = 1'b1; step(); ovr_evt = 1'b0; lsr_rd = 1'b0;
        chk("R9 set wins", lsr[1], 1);
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
        chk("R9 read clears", lsr[1], 0);

        // R10 erroneous characters tally
        do_reset();
        fifo_en = 1'b1;
        rx_wr = 1'b1; rx_wr_err = 1'b1; step(); rx_count = CW'(1);
        rx_wr_err = 1'b0; step(); rx_count = CW'(2);
        rx_wr_err = 1'b1; step(); rx_count = CW'(3);
        rx_wr = 1'b0; rx_wr_err = 1'b0;
        chk("R10 errors held", lsr[7], 1);
        fifo_en = 1'b0;
        #1;
        chk("R10 gated without fifo", lsr[7], 0);
        fifo_en = 1'b1;
        rx_rd = 1'b1; rx_rd_err = 1'b1; step(); rx_count = CW'(2);
        rx_rd_err = 1'b0; step(); rx_count = CW'(1);
        rx_rd = 1'b0;
        chk("R10 one error left", lsr[7], 1);
        rx_rd = 1'b1; rx_rd_err = 1'b1; step(); rx_count = '0;
        rx_rd = 1'b0; rx_rd_err = 1'b0;
        chk("R10 all errors gone", lsr[7], 0);

        // R6 polled mode
        do_reset();
        fifo_en = 1'b1; tx_count = CW'(2); step(); tx_count = '0; step();
        rx_count = CW'(DEPTH - 2); trig_sel = 2'd3; head_par = 1'b1;
        ovr_evt = 1'b1; step(); ovr_evt = 1'b0;
        chk("R6 no irq", irq, 0);
        chk("R6 iid none", iid, 3'b000);
        chk("R6 lsr updates", lsr, 8'h67);
        int_en = 3'b010;
        #1;
        chk("R6 tx latched under mask", iid, 3'b001);

        finish_run();
    end
endmodule